// File: doc/BRIEF.md
# Data Access Alignment Check and Format Unit

This unit sits between the load/store stage of a processor and a 32-bit memory port. For every data access it decides, under one of four modes picked by two control bits, whether the address is misaligned for the access size. A misaligned access in a checking mode is turned into an alignment fault with a fixed status code, and no memory request is issued for it. An access that goes ahead is shaped for the memory side: its low address bits are forced to zero where the mode requires, and word-load data is byte-rotated where the legacy rules require.

The two control bits are `unal_en` and `chk_en`. `{unal_en,chk_en}` = 00 is the legacy mode with no checks. 01 is the legacy mode with natural-alignment checks. 10 lets halfword and word accesses through at any offset but holds doubleword and multiple-register accesses to word alignment. 11 checks halfword, word, doubleword and multiple-register accesses strictly. The decision logic is combinational. A parameter `OUT_REG` adds one register stage on all outputs; its default is 1.

Top module: `align_unit`

## Requirements
- R1: An access of kind 0 (byte) never faults in any mode, and the full address passes unchanged to `mem_addr`.
- R2: In mode 00 no access faults. The memory address forces bit 0 to zero for kind 1 (halfword), bits [1:0] for kind 2 (word), bits [2:0] for kind 3 (doubleword) and bits [1:0] for kind 4 (multiple).
- R3: In mode 00 a word load returns `rd_data` rotated right by 8 times `addr[1:0]`. Every other load, including multiple-register loads and the loads of the other modes, returns `rd_data` unchanged.
- R4: When `chk_en`=1 (modes 01 and 11), a halfword faults if `addr[0]`=1, a word or multiple access faults if `addr[1:0]`≠00, and a doubleword faults if `addr[2:0]`≠000.
- R5: In mode 10 a halfword or word access never faults and passes its address unchanged. A doubleword or multiple access faults unless `addr[1:0]`=00, and the memory address clears bits [1:0] for those two kinds.
- R6: A request that faults drives `mem_valid`=0, `fault`=1 and `fault_code`=ALIGN_CODE (4'h1 by default). A request that does not fault drives `mem_valid`=1, `fault`=0 and `fault_code`=0. With `req_valid`=0 all three outputs are 0.
- R7: With `OUT_REG`=1 each output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, `mem_valid`, `fault` and `fault_code` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request present |
| kind | input | 3 | Access kind: 0 byte, 1 halfword, 2 word, 3 doubleword, 4 multiple |
| is_load | input | 1 | 1 for load, 0 for store |
| addr | input | 32 | Access byte address |
| rd_data | input | 32 | Data read from the memory port |
| unal_en | input | 1 | Mode bit that allows unaligned halfword and word accesses |
| chk_en | input | 1 | Mode bit that enables alignment checking |
| mem_valid | output | 1 | Memory request issued |
| mem_addr | output | 32 | Address sent to memory |
| ld_data | output | 32 | Load data after rotation |
| fault | output | 1 | Alignment fault |
| fault_code | output | 4 | Fault status code, 0 when there is no fault |

## Verification
The assertions assume that `kind` holds only the codes 0 to 4 while `req_valid` is high. They also assume that the inputs change only between clock edges, so that the registered outputs reflect exactly one input set. The bench drives every vector on the falling edge and uses only those five kind codes. It sweeps all four modes against every kind, both load and store, and every address offset from 0 to 7. It never presents a reserved kind, so it stays inside the space the properties cover.

// File: rtl/align_unit.sv
module align_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter logic [CW-1:0] ALIGN_CODE = 4'h1,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    kind,
  input  logic          is_load,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rd_data,
  input  logic          unal_en,
  input  logic          chk_en,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] ld_data,
  output logic          fault,
  output logic [CW-1:0] fault_code
);
  localparam logic [2:0] K_BYTE = 3'd0;
  localparam logic [2:0] K_HALF = 3'd1;
  localparam logic [2:0] K_WORD = 3'd2;
  localparam logic [2:0] K_DBL  = 3'd3;
  localparam logic [2:0] K_MULT = 3'd4;

  logic          mis;
  logic [AW-1:0] addr_n;
  logic [DW-1:0] ld_n;
  logic          mv_n, flt_n, do_rot;
  logic [CW-1:0] code_n;
  logic [2*DW-1:0] dbl;

  always_comb begin
    case (kind)
      K_HALF:  mis = chk_en & addr[0];
      K_WORD:  mis = chk_en & (|addr[1:0]);
      K_DBL:   mis = chk_en ? (|addr[2:0]) : (unal_en & (|addr[1:0]));
      K_MULT:  mis = (chk_en | unal_en) & (|addr[1:0]);
      default: mis = 1'b0;
    endcase
  end

  always_comb begin
    addr_n = addr;
    case (kind)
      K_HALF: if (!unal_en) addr_n[0] = 1'b0;
      K_WORD: if (!unal_en) addr_n[1:0] = 2'b00;
      K_DBL: begin
        if (!unal_en) addr_n[2:0] = 3'b000;
        else          addr_n[1:0] = 2'b00;
      end
      K_MULT: addr_n[1:0] = 2'b00;
      default: ;
    endcase
  end

  assign do_rot = !unal_en && !chk_en && kind == K_WORD && is_load;
  assign dbl    = {rd_data, rd_data} >> {addr[1:0], 3'b000};
  assign ld_n   = do_rot ? dbl[DW-1:0] : rd_data;
  assign flt_n  = req_valid & mis;
  assign mv_n   = req_valid & ~mis;
  assign code_n = flt_n ? ALIGN_CODE : '0;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mem_valid  <= 1'b0;
          fault      <= 1'b0;
          fault_code <= '0;
          mem_addr   <= '0;
          ld_data    <= '0;
        end else begin
          mem_valid  <= mv_n;
          fault      <= flt_n;
          fault_code <= code_n;
          mem_addr   <= addr_n;
          ld_data    <= ld_n;
        end
      end
    end else begin : g_comb
      assign mem_valid  = mv_n;
      assign fault      = flt_n;
      assign fault_code = code_n;
      assign mem_addr   = addr_n;
      assign ld_data    = ld_n;
    end
  endgenerate

  // R1
  byte_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BYTE) |-> (!flt_n && addr_n == addr));
  // R2
  legacy_open_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unal_en && !chk_en) |-> !flt_n);
  // R3
  mult_load_unrotated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_MULT && is_load) |-> (ld_n == rd_data));
  // R4
  strict_word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && mv_n && (kind == K_WORD || kind == K_MULT)) |-> (addr[1:0] == 2'b00));
  // R5
  unal_half_word_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unal_en && !chk_en && req_valid && (kind == K_HALF || kind == K_WORD))
      |-> (mv_n && addr_n == addr));
  // R6
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && fault) && (fault == (fault_code != '0)));
  // R7
  out_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && $past(rst_n)) |-> (fault == $past(flt_n) && mem_valid == $past(mv_n)));
endmodule

// File: tb/tb_align_unit.sv
`timescale 1ns/1ps
module tb_align_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic        is_load = 1'b0;
  logic [31:0] addr = '0;
  logic [31:0] rd_data = '0;
  logic        unal_en = 1'b0;
  logic        chk_en = 1'b0;
  logic        mem_valid, fault;
  logic [31:0] mem_addr, ld_data;
  logic [3:0]  fault_code;

  int vecs = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  align_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .kind(kind), .is_load(is_load),
    .addr(addr), .rd_data(rd_data), .unal_en(unal_en), .chk_en(chk_en),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .ld_data(ld_data),
    .fault(fault), .fault_code(fault_code)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h (mode %b kind %0d ld %b addr %h)",
               req, what, act, exp, {unal_en, chk_en}, kind, is_load, addr);
    end
  endtask

  function automatic logic model_fault(input logic u, input logic a, input int k, input logic [31:0] ad);
    if (k == 0) return 1'b0;
    if (a) begin
      if (k == 1) return ad[0];
      if (k == 3) return ad[2:0] != 3'b000;
      return ad[1:0] != 2'b00;
    end
    if (u && (k == 3 || k == 4)) return ad[1:0] != 2'b00;
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_addr(input logic u, input int k, input logic [31:0] ad);
    if (k == 4) return {ad[31:2], 2'b00};
    if (u) return (k == 3) ? {ad[31:2], 2'b00} : ad;
    case (k)
      1: return {ad[31:1], 1'b0};
      2: return {ad[31:2], 2'b00};
      3: return {ad[31:3], 3'b000};
      default: return ad;
    endcase
  endfunction

  function automatic logic [31:0] model_data(input logic u, input logic a, input int k, input logic ld,
                                             input logic [1:0] off, input logic [31:0] d);
    if (u || a || k != 2 || !ld) return d;
    case (off)
      2'd1: return {d[7:0], d[31:8]};
      2'd2: return {d[15:0], d[31:16]};
      2'd3: return {d[23:0], d[31:24]};
      default: return d;
    endcase
  endfunction

  function automatic string tag_of(input logic u, input logic a, input int k, input logic ld);
    if (k == 0) return "R1";
    if (!u && !a) return (ld && (k == 2 || k == 4)) ? "R3" : "R2";
    if (a) return "R4";
    return "R5";
  endfunction

  task automatic apply_and_check(input logic [31:0] base, input int k, input logic ld, input int off);
    logic f;
    string t;
    @(negedge clk);
    req_valid = 1'b1;
    kind = 3'(k);
    is_load = ld;
    addr = base + 32'(off);
    rd_data = 32'hA1B2C3D4 ^ {base[7:0], base[7:0], 16'h0};
    @(negedge clk);
    f = model_fault(unal_en, chk_en, k, addr);
    t = tag_of(unal_en, chk_en, k, ld);
    chk(t, "fault", {31'b0, fault}, {31'b0, f});
    chk("R6", "fault_code", {28'b0, fault_code}, f ? 32'h1 : 32'h0);
    chk("R6", "mem_valid", {31'b0, mem_valid}, {31'b0, !f});
    if (!f) begin
      chk(t, "mem_addr", mem_addr, model_addr(unal_en, k, addr));
      if (ld) chk(t, "ld_data", ld_data, model_data(unal_en, chk_en, k, ld, addr[1:0], rd_data));
    end
  endtask

  task automatic sweep_mode(input logic u, input logic a);
    unal_en = u;
    chk_en = a;
    for (int k = 0; k < 5; k++)
      for (int l = 0; l < 2; l++)
        for (int off = 0; off < 8; off++)
          apply_and_check(32'h4000_1230 + 32'(k) * 32'h100, k, l[0], off);
  endtask

  task automatic reset_check();
    rst_n = 1'b0;
    req_valid = 1'b1;
    kind = 3'd2;
    chk_en = 1'b1;
    addr = 32'h0000_0003;
    repeat (3) @(negedge clk);
    chk("R7", "reset mem_valid", {31'b0, mem_valid}, 32'h0);
    chk("R7", "reset fault", {31'b0, fault}, 32'h0);
    chk("R7", "reset fault_code", {28'b0, fault_code}, 32'h0);
    req_valid = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_valid = 1'b0;
    unal_en = 1'b1;
    chk_en = 1'b1;
    kind = 3'd2;
    addr = 32'h0000_0001;
    @(negedge clk);
    chk("R6", "idle mem_valid", {31'b0, mem_valid}, 32'h0);
    chk("R6", "idle fault", {31'b0, fault}, 32'h0);
    chk("R6", "idle fault_code", {28'b0, fault_code}, 32'h0);
  endtask

  task automatic latency_check();
    unal_en = 1'b0;
    chk_en = 1'b1;
    @(negedge clk);
    req_valid = 1'b1;
    kind = 3'd2;
    addr = 32'h0000_0100;
    @(negedge clk);
    chk("R7", "aligned accepted", {31'b0, mem_valid}, 32'h1);
    addr = 32'h0000_0102;
    #1;
    chk("R7", "output holds before edge", {31'b0, fault}, 32'h0);
    @(negedge clk);
    chk("R7", "fault after one edge", {31'b0, fault}, 32'h1);
    chk("R7", "valid dropped after one edge", {31'b0, mem_valid}, 32'h0);
    req_valid = 1'b0;
  endtask

  initial begin
    reset_check();
    idle_check();
    sweep_mode(1'b0, 1'b0);
    sweep_mode(1'b0, 1'b1);
    sweep_mode(1'b1, 1'b0);
    sweep_mode(1'b1, 1'b1);
    latency_check();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule